// File: doc/BRIEF.md
# Two-Channel Packet Link Arbiter and Receive Steering

This block sits between a node's packet engines and a single serial link. On the transmit side, two packet sources share one link transmit FIFO. Source 0 carries automatically generated remote-access replies. Source 1 carries packets that user software queued. The arbiter hands the link over one whole packet at a time. Whenever a new packet may start, source 0 wins over source 1.

On the receive side, a steering unit splits the incoming link byte stream into two receive channels. It reads the protocol identifier, which is the second byte of each packet:
- A packet whose identifier equals the configured virtual-channel protocol value goes to receive channel 1.
- Every other packet goes to receive channel 0. This covers remote-access replies, remote-access commands not handled in hardware, and any other protocol.
- A packet with fewer than two bytes also goes to channel 0.

The two directions share nothing but clock and reset, so they run at the same time.

Every data interface is valid/ready, with bytes carrying a `last` flag on the final byte of a packet:
- A byte moves on a clock edge where valid and ready are both high.
- A source that raises valid must hold it, with data and `last` unchanged, until the byte is taken.
- The link side may hold ready low for any number of cycles. No byte is lost or repeated.
- Until the first byte of a packet has been taken, the byte offered on the link may be replaced by one from a higher-priority source that has just become valid.

Top module: `vc_link_mux`

## Requirements
- R1: While reset is held and after its release with no input valid, `link_tx_valid` and both `rx_ch_valid` bits are low.
- R2: When no packet is in progress and both sources are valid, the link is fed from source 0. With only one source valid, that source is fed.
- R3: Once the first byte of a multi-byte packet has been accepted by the link, only that source is connected (its `tx_ready` follows `link_tx_ready`, the other's is low) until its `last` byte is accepted.
- R4: The granted source's ready equals `link_tx_ready`. `link_tx_data` and `link_tx_last` show the granted source's current byte, so the link sees every byte of each source once and in order.
- R5: A one-byte packet (first byte carries `last`) releases the grant on the cycle it is accepted. The next cycle is arbitrated afresh.
- R6: A received packet whose second byte equals `cfg_vc_pid` is delivered, every byte in order, on receive channel 1. Packets of two or more bytes whose second byte differs go to channel 0.
- R7: A received packet of a single byte is delivered on receive channel 0.
- R8: Receive channel outputs are never valid together. A channel holding valid without ready keeps its byte stable, and back-pressure stalls the link input without loss.
- R9: Transmit and receive traffic proceed concurrently without affecting each other's byte streams.
- R10: Source 1 alone, with source 0 idle, gets the full link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 2 | Per-source byte valid (bit 0 = reply source) |
| tx_data | input | 16 | Source bytes, source n in bits [8n+7:8n] |
| tx_last | input | 2 | Per-source end-of-packet flag |
| tx_ready | output | 2 | Per-source byte accepted |
| link_tx_valid | output | 1 | Byte offered to link FIFO |
| link_tx_data | output | 8 | Byte to link FIFO |
| link_tx_last | output | 1 | End-of-packet to link FIFO |
| link_tx_ready | input | 1 | Link FIFO can take a byte |
| link_rx_valid | input | 1 | Received byte valid |
| link_rx_data | input | 8 | Received byte |
| link_rx_last | input | 1 | Received end-of-packet |
| link_rx_ready | output | 1 | Steering unit takes the received byte |
| cfg_vc_pid | input | 8 | Protocol identifier routed to receive channel 1 |
| rx_ch_valid | output | 2 | Per receive channel byte valid |
| rx_ch_data | output | 16 | Receive channel bytes, channel n in bits [8n+7:8n] |
| rx_ch_last | output | 2 | Per receive channel end-of-packet |
| rx_ch_ready | input | 2 | Per receive channel consumer ready |

## Verification
The assertions check the following on every cycle:
- Only one source sees ready.
- The reply source shuts out the user source at a packet boundary.
- The owner of a packet in flight keeps the link.
- A stalled mid-packet link byte stays stable.
- At most one receive channel is valid, and a stalled receive byte stays stable.
- A single-byte packet is flushed to channel 0.

Only the bench scenarios can show the following:
- Whole packets reach the link in the right order when priorities collide.
- Bytes are neither lost nor duplicated under irregular back-pressure.
- Packets land on the right receive channel for matching, non-matching and short identifiers.
- Transmit and receive do not disturb each other under simultaneous traffic.

// File: rtl/vclink_pkg.sv
package vclink_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_PEEK  = 2'd1,
    RX_FLUSH = 2'd2,
    RX_PASS  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/vc_tx_arb.sv
module vc_tx_arb #(
  parameter int NCH = 2,
  parameter int W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   src_valid,
  input  logic [NCH*W-1:0] src_data,
  input  logic [NCH-1:0]   src_last,
  output logic [NCH-1:0]   src_ready,
  output logic             lnk_valid,
  output logic [W-1:0]     lnk_data,
  output logic             lnk_last,
  input  logic             lnk_ready
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic          busy;
  logic [IW-1:0] owner;
  logic [IW-1:0] pick;
  logic [IW-1:0] sel;
  logic          fire;

  // lowest index wins: scan from the top so the last hit is the smallest
  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (src_valid[i]) pick = IW'(i);
    end
  end

  always_comb begin
    sel       = busy ? owner : pick;
    lnk_valid = src_valid[sel];
    lnk_data  = src_data[sel*W +: W];
    lnk_last  = src_last[sel];
    src_ready = '0;
    src_ready[sel] = lnk_ready;
  end

  assign fire = lnk_valid && lnk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      owner <= '0;
    end else if (fire) begin
      busy  <= !lnk_last;
      owner <= sel;
    end
  end

  // R4
  tx_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ready));

  // R2
  tx_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && src_valid[0]) |-> !src_ready[NCH-1]);

  // R3
  tx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !lnk_last) |=> (busy && owner == $past(sel)));

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lnk_valid && !lnk_ready) |=>
      (lnk_valid && $stable(lnk_data) && $stable(lnk_last)));
endmodule

// File: rtl/vc_rx_steer.sv
module vc_rx_steer
  import vclink_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   cfg_pid,
  input  logic           in_valid,
  input  logic [W-1:0]   in_data,
  input  logic           in_last,
  output logic           in_ready,
  output logic [1:0]     out_valid,
  output logic [2*W-1:0] out_data,
  output logic [1:0]     out_last,
  input  logic [1:0]     out_ready
);
  rx_state_e    st;
  logic [W-1:0] hold_d;
  logic         hold_l;
  logic         dest;
  logic [W-1:0] cur_d;
  logic         cur_l;

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 2'b00;
    cur_d     = hold_d;
    cur_l     = hold_l;
    unique case (st)
      RX_IDLE:  in_ready = 1'b1;
      RX_PEEK:  in_ready = 1'b0;
      RX_FLUSH: out_valid[dest] = 1'b1;
      RX_PASS: begin
        out_valid[dest] = in_valid;
        in_ready        = out_ready[dest];
        cur_d           = in_data;
        cur_l           = in_last;
      end
      default: in_ready = 1'b0;
    endcase
    out_data = {2{cur_d}};
    out_last = {2{cur_l}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      hold_d <= '0;
      hold_l <= 1'b0;
      dest   <= 1'b0;
    end else begin
      unique case (st)
        RX_IDLE: if (in_valid) begin
          hold_d <= in_data;
          hold_l <= in_last;
          if (in_last) begin
            dest <= 1'b0;
            st   <= RX_FLUSH;
          end else begin
            st <= RX_PEEK;
          end
        end
        RX_PEEK: if (in_valid) begin
          dest <= (in_data == cfg_pid);
          st   <= RX_FLUSH;
        end
        RX_FLUSH: if (out_ready[dest]) st <= hold_l ? RX_IDLE : RX_PASS;
        RX_PASS: if (in_valid && out_ready[dest] && in_last) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end

  // R8
  rx_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid));

  // R8
  rx_hold0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid[0] && !out_ready[0]) |=>
      (out_valid[0] && $stable(out_data[W-1:0]) && $stable(out_last[0])));

  // R8
  rx_hold1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid[1] && !out_ready[1]) |=>
      (out_valid[1] && $stable(out_data[2*W-1:W]) && $stable(out_last[1])));

  // R7
  rx_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_IDLE && in_valid && in_last) |=> (out_valid[0] && out_last[0]));
endmodule

// File: rtl/vc_link_mux.sv
module vc_link_mux #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     tx_valid,
  input  logic [2*W-1:0] tx_data,
  input  logic [1:0]     tx_last,
  output logic [1:0]     tx_ready,
  output logic           link_tx_valid,
  output logic [W-1:0]   link_tx_data,
  output logic           link_tx_last,
  input  logic           link_tx_ready,
  input  logic           link_rx_valid,
  input  logic [W-1:0]   link_rx_data,
  input  logic           link_rx_last,
  output logic           link_rx_ready,
  input  logic [W-1:0]   cfg_vc_pid,
  output logic [1:0]     rx_ch_valid,
  output logic [2*W-1:0] rx_ch_data,
  output logic [1:0]     rx_ch_last,
  input  logic [1:0]     rx_ch_ready
);
  vc_tx_arb #(.NCH(2), .W(W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_valid (tx_valid),
    .src_data  (tx_data),
    .src_last  (tx_last),
    .src_ready (tx_ready),
    .lnk_valid (link_tx_valid),
    .lnk_data  (link_tx_data),
    .lnk_last  (link_tx_last),
    .lnk_ready (link_tx_ready)
  );

  vc_rx_steer #(.W(W)) u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_pid   (cfg_vc_pid),
    .in_valid  (link_rx_valid),
    .in_data   (link_rx_data),
    .in_last   (link_rx_last),
    .in_ready  (link_rx_ready),
    .out_valid (rx_ch_valid),
    .out_data  (rx_ch_data),
    .out_last  (rx_ch_last),
    .out_ready (rx_ch_ready)
  );
endmodule

// File: tb/tb_vc_link_mux.sv
module tb_vc_link_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  tx_valid = '0;
  logic [15:0] tx_data = '0;
  logic [1:0]  tx_last = '0;
  logic [1:0]  tx_ready;
  logic        link_tx_valid;
  logic [7:0]  link_tx_data;
  logic        link_tx_last;
  logic        link_tx_ready = 1'b1;
  logic        link_rx_valid = 1'b0;
  logic [7:0]  link_rx_data = '0;
  logic        link_rx_last = 1'b0;
  logic        link_rx_ready;
  logic [7:0]  cfg_vc_pid = 8'h5A;
  logic [1:0]  rx_ch_valid;
  logic [15:0] rx_ch_data;
  logic [1:0]  rx_ch_last;
  logic [1:0]  rx_ch_ready = 2'b11;

  vc_link_mux dut (.*);

  always #2 clk = ~clk;

  int checks = 0, bad = 0, cyc = 0;
  int lr_mode = 0, or_mode = 0, gap = 0;
  bit run = 0, finished = 0;
  logic [8:0] sq0[$], sq1[$], rq[$], eq0[$], eq1[$];
  string tg0[$], tg1[$];
  bit tv0 = 0, tv1 = 0, rv = 0, mbusy = 0;
  int mown = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_tx(input int ch, input int len, input int base);
    for (int i = 0; i < len; i++) begin
      if (ch == 0) sq0.push_back({i == len - 1, 8'(base + i)});
      else         sq1.push_back({i == len - 1, 8'(base + i)});
    end
  endtask

  task automatic push_rx(input int len, input logic [7:0] pid, input int base);
    bit d;
    string t;
    d = (len >= 2) && (pid == cfg_vc_pid);
    t = (len < 2) ? "R7" : "R6";
    for (int i = 0; i < len; i++) begin
      logic [8:0] b;
      b = {i == len - 1, (i == 1) ? pid : 8'(base + i)};
      rq.push_back(b);
      if (d) begin eq1.push_back(b); tg1.push_back(t); end
      else   begin eq0.push_back(b); tg0.push_back(t); end
    end
  endtask

  task automatic drain();
    int n;
    n = 0;
    while ((sq0.size() + sq1.size() + rq.size() + eq0.size() + eq1.size()) != 0
           && n < 5000) begin
      @(posedge clk);
      n++;
    end
    chk(n < 5000, "R8", "drain timeout", n, 0);
    repeat (3) @(posedge clk);
  endtask

  always @(negedge clk) if (run) begin
    int sel, ev;
    logic [8:0] fr;
    cyc++;
    if (!tv0 && sq0.size() > 0 && (gap == 0 || cyc % 5 != 1)) tv0 = 1;
    if (!tv1 && sq1.size() > 0 && (gap == 0 || cyc % 5 != 2)) tv1 = 1;
    tx_valid = {tv1, tv0};
    tx_data  = {(sq1.size() > 0) ? sq1[0][7:0] : 8'h0,
                (sq0.size() > 0) ? sq0[0][7:0] : 8'h0};
    tx_last  = {(sq1.size() > 0) ? sq1[0][8] : 1'b0,
                (sq0.size() > 0) ? sq0[0][8] : 1'b0};
    link_tx_ready = (lr_mode == 0) ? 1'b1 : (cyc % 3 != 0);
    if (!rv && rq.size() > 0 && (gap == 0 || cyc % 4 != 1)) rv = 1;
    link_rx_valid = rv;
    link_rx_data  = (rq.size() > 0) ? rq[0][7:0] : 8'h0;
    link_rx_last  = (rq.size() > 0) ? rq[0][8] : 1'b0;
    rx_ch_ready = (or_mode == 0) ? 2'b11 : {cyc % 2 == 0, cyc % 3 != 0};
    #1;
    // transmit reference: grant held mid-packet, else source 0 first
    if (mbusy) sel = mown;
    else       sel = tv0 ? 0 : (tv1 ? 1 : 0);
    ev = (sel == 0) ? tv0 : tv1;
    chk(link_tx_valid == ev, mbusy ? "R3" : "R2", "link valid",
        link_tx_valid, ev);
    chk(tx_ready == (2'(link_tx_ready) << sel), "R4", "source ready",
        tx_ready, 2'(link_tx_ready) << sel);
    if (ev) begin
      fr = (sel == 0) ? sq0[0] : sq1[0];
      chk({link_tx_last, link_tx_data} == fr, "R4", "link byte",
          {link_tx_last, link_tx_data}, fr);
      if (link_tx_ready) begin
        if (sel == 0) begin void'(sq0.pop_front()); tv0 = 0; end
        else          begin void'(sq1.pop_front()); tv1 = 0; end
        mbusy = !fr[8];   // R5: one-byte packet leaves mbusy low
        mown  = sel;
      end
    end
    // receive reference
    chk(!(rx_ch_valid[0] && rx_ch_valid[1]), "R8", "both rx valid",
        rx_ch_valid, 0);
    if (rx_ch_valid[0] && rx_ch_ready[0]) begin
      if (eq0.size() == 0) chk(0, "R6", "unexpected ch0 byte", rx_ch_data[7:0], 0);
      else begin
        chk({rx_ch_last[0], rx_ch_data[7:0]} == eq0[0], tg0[0], "ch0 byte",
            {rx_ch_last[0], rx_ch_data[7:0]}, eq0[0]);
        void'(eq0.pop_front()); void'(tg0.pop_front());
      end
    end
    if (rx_ch_valid[1] && rx_ch_ready[1]) begin
      if (eq1.size() == 0) chk(0, "R6", "unexpected ch1 byte", rx_ch_data[15:8], 0);
      else begin
        chk({rx_ch_last[1], rx_ch_data[15:8]} == eq1[0], tg1[0], "ch1 byte",
            {rx_ch_last[1], rx_ch_data[15:8]}, eq1[0]);
        void'(eq1.pop_front()); void'(tg1.pop_front());
      end
    end
    if (rv && link_rx_ready) begin void'(rq.pop_front()); rv = 0; end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: outputs idle during reset
    chk(link_tx_valid == 1'b0, "R1", "tx valid in reset", link_tx_valid, 0);
    chk(rx_ch_valid == 2'b00, "R1", "rx valid in reset", rx_ch_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(link_tx_valid == 1'b0, "R1", "tx valid after reset", link_tx_valid, 0);
    chk(rx_ch_valid == 2'b00, "R1", "rx valid after reset", rx_ch_valid, 0);
    run = 1;

    // R10: user source alone
    push_tx(1, 4, 8'h10); push_tx(1, 2, 8'h20);
    drain();
    // R2: simultaneous arrival, reply source must come first
    push_tx(1, 3, 8'h30); push_tx(0, 3, 8'h40);
    drain();
    // R3: user packet in flight is not interrupted by a late reply
    push_tx(1, 8, 8'h50);
    repeat (3) @(posedge clk);
    push_tx(0, 2, 8'h60);
    drain();
    // R5: single-byte packets on both sources
    push_tx(0, 1, 8'h70); push_tx(0, 1, 8'h71);
    push_tx(1, 1, 8'h72); push_tx(1, 1, 8'h73);
    drain();
    // R6, R7: receive steering
    push_rx(5, 8'h5A, 8'h80);
    push_rx(4, 8'h01, 8'h90);
    push_rx(1, 8'h00, 8'hA0);
    push_rx(2, 8'h5A, 8'hB0);
    push_rx(2, 8'h5B, 8'hC0);
    drain();
    // R4, R8: irregular back-pressure on both sides and source gaps
    lr_mode = 1; or_mode = 1; gap = 1;
    push_tx(1, 6, 8'hD0); push_tx(0, 5, 8'hE0); push_tx(1, 1, 8'hF0);
    push_tx(0, 3, 8'h05);
    push_rx(6, 8'h5A, 8'h11); push_rx(1, 8'h00, 8'h22);
    push_rx(3, 8'h77, 8'h33);
    drain();
    // R9: concurrent transmit and receive with a new identifier
    cfg_vc_pid = 8'h33;
    for (int k = 0; k < 6; k++) begin
      push_tx(k % 2, 3 + k, 8'h40 + 16 * k);
      push_rx(2 + k, (k % 2 == 0) ? 8'h33 : 8'h5A, 8'h08 * k);
    end
    drain();
    lr_mode = 0; or_mode = 0; gap = 0;
    run = 0;
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule